// File: doc/BRIEF.md
# Priority Express/Preempt Queue Mapper

This block decides which of two transmit queues each of eight traffic priorities uses. One queue is the express queue. The other holds preemptable traffic. Software writes an 8-bit mask, where bit i belongs to priority i. The block keeps a saturating occupancy count for every priority. The count goes up on each enqueue and down on each dequeue reported for that priority.

A newly written mask does not move a priority at once. The block holds the mask as pending. A priority adopts its new mapping only on a cycle where its own count is zero and no enqueue for it arrives. This keeps frames already queued on a priority in order.

Every enqueue is routed with the effective mapping of its own cycle. A per-priority pending-change vector lets software poll until all switches have completed. While the verification status input is low, the target mapping for every priority is express, and each priority falls back to express as soon as it drains.

Top module: `prio_queue_mapper`

## Requirements
- R1: After reset the effective mask, the pending-change vector and the underflow flag are all zero, and no enqueue is routed to the preemptable queue.
- R2: Mask bit i belongs to priority i. When the effective bit is 1, enqueues of that priority go to the preemptable queue (`enqToPreempt`=1). When it is 0, they go to the express queue (`enqToPreempt`=0).
- R3: A written mask is held pending. An effective bit takes its target value at the clock edge that ends a cycle where that priority's count is zero and `enqValid` with `enqPrio`=i is not asserted. Otherwise the effective bit holds.
- R4: `enqToPreempt` uses the effective bit in force during the enqueue cycle, never the pending bit, and is 0 when `enqValid` is low.
- R5: Bit i of `pendChange` is 1 exactly when priority i's target bit differs from its effective bit.
- R6: An enqueue and a dequeue for the same priority in the same cycle leave that priority's count unchanged.
- R7: Each count saturates at 2^CNT_W-1, which is 15 by default. Further enqueues do not change it.
- R8: A dequeue for a priority whose count is zero sets `underflowErr`. The flag stays set until reset, and the count stays at zero.
- R9: While `verifyOk` is low, every target bit is 0 (express). When `verifyOk` is high, the target is the last written mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| verifyOk | input | 1 | Preemption verification succeeded |
| maskWr | input | 1 | Write strobe for the preempt mask |
| maskData | input | 8 | New mask value; bit i = priority i goes to preempt queue |
| enqValid | input | 1 | An enqueue occurs this cycle |
| enqPrio | input | 3 | Priority of the enqueue |
| deqValid | input | 1 | A dequeue occurs this cycle |
| deqPrio | input | 3 | Priority of the dequeue |
| enqToPreempt | output | 1 | Enqueue this cycle goes to the preemptable queue |
| effMask | output | 8 | Effective mapping per priority |
| pendChange | output | 8 | Target and effective mapping differ |
| underflowErr | output | 1 | Sticky dequeue-at-zero error |

## Verification
The hardest situation to reach from the ports is a priority that drains while the block is still refusing to switch it. The block refuses in three cases: when a fresh enqueue arrives in the very cycle the count reaches zero, when an enqueue and a dequeue cancel, and when a saturated count has to be worked down. The stimulus builds these with exact enqueue and dequeue counts against a pending mask. It then checks that the effective bit moves only on the first idle cycle at zero. A loss of verification while a preempt priority is still occupied is staged the same way, so that the fallback to express has to wait for the drain.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int PRIO_N = 8;
  localparam int PRIO_W = $clog2(PRIO_N);

  // strobes from control to datapath
  typedef struct packed {
    logic [PRIO_N-1:0] enqHit;
    logic [PRIO_N-1:0] deqHit;
    logic [PRIO_N-1:0] target;
  } ctrl_t;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              verifyOk,
  input  logic              maskWr,
  input  logic [PRIO_N-1:0] maskData,
  input  logic              enqValid,
  input  logic [PRIO_W-1:0] enqPrio,
  input  logic              deqValid,
  input  logic [PRIO_W-1:0] deqPrio,
  output ctrl_t             strb
);
  logic [PRIO_N-1:0] pendMask;

  always_ff @(posedge clk) begin
    if (!rstN)       pendMask <= '0;
    else if (maskWr) pendMask <= maskData;
  end

  for (genvar i = 0; i < PRIO_N; i++) begin : g_dec
    assign strb.enqHit[i] = enqValid && (enqPrio == PRIO_W'(i));
    assign strb.deqHit[i] = deqValid && (deqPrio == PRIO_W'(i));
  end

  // unverified link: everything heads back to express
  assign strb.target = verifyOk ? pendMask : '0;
endmodule

// File: rtl/mapper_dp.sv
module mapper_dp
  import mapper_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strb,
  output logic [PRIO_N-1:0] effMask,
  output logic [PRIO_N-1:0] pendChange,
  output logic              underflowErr
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRIO_N-1:0] isEmpty;
  logic [PRIO_N-1:0] underHit;

  for (genvar i = 0; i < PRIO_N; i++) begin : g_prio
    logic [CNT_W-1:0] occ;
    logic enq, deq;
    assign enq = strb.enqHit[i];
    assign deq = strb.deqHit[i];
    assign isEmpty[i] = (occ == '0);
    assign underHit[i] = deq && !enq && isEmpty[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        occ <= '0;
      end else if (enq && !deq) begin
        if (occ != CNT_MAX) occ <= occ + 1'b1;
      end else if (deq && !enq) begin
        if (!isEmpty[i]) occ <= occ - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                   effMask[i] <= 1'b0;
      else if (isEmpty[i] && !enq) effMask[i] <= strb.target[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          underflowErr <= 1'b0;
    else if (|underHit) underflowErr <= 1'b1;
  end

  assign pendChange = strb.target ^ effMask;
endmodule

// File: rtl/prio_queue_mapper.sv
module prio_queue_mapper
  import mapper_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              verifyOk,
  input  logic              maskWr,
  input  logic [PRIO_N-1:0] maskData,
  input  logic              enqValid,
  input  logic [PRIO_W-1:0] enqPrio,
  input  logic              deqValid,
  input  logic [PRIO_W-1:0] deqPrio,
  output logic              enqToPreempt,
  output logic [PRIO_N-1:0] effMask,
  output logic [PRIO_N-1:0] pendChange,
  output logic              underflowErr
);
  ctrl_t strb;

  mapper_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .verifyOk(verifyOk),
    .maskWr(maskWr), .maskData(maskData),
    .enqValid(enqValid), .enqPrio(enqPrio),
    .deqValid(deqValid), .deqPrio(deqPrio),
    .strb(strb)
  );

  mapper_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .effMask(effMask), .pendChange(pendChange),
    .underflowErr(underflowErr)
  );

  assign enqToPreempt = enqValid && effMask[enqPrio];
endmodule

// File: rtl/prio_queue_mapper_chk.sv
module prio_queue_mapper_chk
  import mapper_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              verifyOk,
  input logic              enqValid,
  input logic [PRIO_W-1:0] enqPrio,
  input logic              enqToPreempt,
  input logic [PRIO_N-1:0] effMask,
  input logic [PRIO_N-1:0] pendChange,
  input logic              underflowErr
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr); // R8

  AST_NO_SWITCH_ON_ENQ: assert property (@(posedge clk) disable iff (!rstN)
    enqValid |=> effMask[$past(enqPrio)] == $past(effMask[enqPrio])); // R3

  AST_ONLY_PENDING_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    ##1 (((effMask ^ $past(effMask)) & ~$past(pendChange)) == '0)); // R5

  AST_UNVERIFIED_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !verifyOk |=> ((effMask & ~$past(effMask)) == '0)); // R9

  AST_IDLE_NO_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    !enqValid |-> !enqToPreempt); // R4
endmodule

bind prio_queue_mapper prio_queue_mapper_chk u_chk (
  .clk(clk), .rstN(rstN), .verifyOk(verifyOk),
  .enqValid(enqValid), .enqPrio(enqPrio), .enqToPreempt(enqToPreempt),
  .effMask(effMask), .pendChange(pendChange), .underflowErr(underflowErr)
);

// File: tb/prio_queue_mapper_test.sv
module prio_queue_mapper_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       verifyOk = 1'b1;
  logic       maskWr = 1'b0;
  logic [7:0] maskData = '0;
  logic       enqValid = 1'b0;
  logic [2:0] enqPrio = '0;
  logic       deqValid = 1'b0;
  logic [2:0] deqPrio = '0;
  logic       enqToPreempt;
  logic [7:0] effMask, pendChange;
  logic       underflowErr;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  prio_queue_mapper uut (
    .clk(clk), .rstN(rstN), .verifyOk(verifyOk),
    .maskWr(maskWr), .maskData(maskData),
    .enqValid(enqValid), .enqPrio(enqPrio),
    .deqValid(deqValid), .deqPrio(deqPrio),
    .enqToPreempt(enqToPreempt), .effMask(effMask),
    .pendChange(pendChange), .underflowErr(underflowErr)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive after negedge, hold for one clock, sample 1 ns after posedge
  task automatic step(input logic wr, input logic [7:0] d, input logic v,
                      input logic eV, input logic [2:0] eP,
                      input logic dV, input logic [2:0] dP);
    @(negedge clk);
    maskWr = wr; maskData = d; verifyOk = v;
    enqValid = eV; enqPrio = eP; deqValid = dV; deqPrio = dP;
    @(posedge clk); #1;
  endtask

  // {wr, data, verify, enqV, enqP, deqV, deqP, expRoute, expEff, expPend}
  localparam logic [34:0] VEC [0:15] = '{
    {1'b1, 8'h01, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 8'h00, 8'h01},
    {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 8'h01, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b1, 3'd0, 1'b0, 3'd0, 1'b1, 8'h01, 8'h00},
    {1'b1, 8'h00, 1'b1, 1'b1, 3'd0, 1'b0, 3'd0, 1'b1, 8'h01, 8'h01},
    {1'b0, 8'h00, 1'b1, 1'b1, 3'd1, 1'b1, 3'd0, 1'b0, 8'h01, 8'h01},
    {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 8'h01, 8'h01},
    {1'b0, 8'h00, 1'b1, 1'b1, 3'd0, 1'b0, 3'd0, 1'b1, 8'h01, 8'h01},
    {1'b0, 8'h00, 1'b1, 1'b1, 3'd0, 1'b1, 3'd0, 1'b1, 8'h01, 8'h01},
    {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 8'h01, 8'h01},
    {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00},
    {1'b1, 8'h82, 1'b1, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 8'h00, 8'h82},
    {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 8'h82, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0, 1'b1, 8'h80, 8'h80},
    {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 3'd7, 1'b0, 8'h80, 8'h80},
    {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 8'h82, 8'h00}
  };

  initial begin
    // R1: reset state, with an enqueue offered during reset
    enqValid = 1'b1; enqPrio = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 effMask", effMask, 8'h00);
    chk("R1 pendChange", pendChange, 8'h00);
    chk("R1 underflowErr", {7'd0, underflowErr}, 8'h00);
    chk("R1 route", {7'd0, enqToPreempt}, 8'h00);
    @(negedge clk); rstN = 1'b1; enqValid = 1'b0;

    // R2 R3 R4 R5 R6 R9: table walk
    for (int k = 0; k < 16; k++) begin
      logic [34:0] v;
      v = VEC[k];
      @(negedge clk);
      maskWr = v[34]; maskData = v[33:26]; verifyOk = v[25];
      enqValid = v[24]; enqPrio = v[23:21]; deqValid = v[20]; deqPrio = v[19:17];
      #2;
      chk($sformatf("R4 R2 route row %0d", k), {7'd0, enqToPreempt}, {7'd0, v[16]});
      @(posedge clk); #1;
      chk($sformatf("R3 R9 effMask row %0d", k), effMask, v[15:8]);
      chk($sformatf("R5 pendChange row %0d", k), pendChange, v[7:0]);
    end

    // R7: saturation of priority 2's count
    step(1'b1, 8'h86, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    step(1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    chk("R2 effMask after 0x86", effMask, 8'h86);
    for (int k = 0; k < 17; k++) step(1'b0, 8'h00, 1'b1, 1'b1, 3'd2, 1'b0, 3'd0);
    step(1'b1, 8'h82, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    chk("R3 pending while occupied", pendChange, 8'h04);
    for (int k = 0; k < 14; k++) step(1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 3'd2);
    step(1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    chk("R7 count held at max, one left", effMask, 8'h86);
    chk("R7 no underflow", {7'd0, underflowErr}, 8'h00);
    step(1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 3'd2);
    step(1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    chk("R7 drained after max", effMask, 8'h82);

    // R8: underflow is sticky and the count stays at zero
    step(1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 3'd3);
    chk("R8 underflow set", {7'd0, underflowErr}, 8'h01);
    step(1'b1, 8'h8A, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    step(1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    chk("R8 underflow sticky", {7'd0, underflowErr}, 8'h01);
    chk("R8 count stayed zero", effMask, 8'h8A);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #1000000;
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule